// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block turns three digital supply-supervision inputs into one system reset. The inputs are a power-good flag, a flag that says the supply is below its trip point, and an active-low push-button reset. While any of these causes is active, the reset is asserted. After the last cause goes away, the reset stays asserted for a hold-off time. A 2-bit code selects this time.

Time is measured in ticks of a 1 kHz enable strobe. A single clock source can therefore drive both the hold-off counter and the push-button debounce. The push-button input is debounced before it counts as a cause.

The reset comes out in both polarities. Two single-cycle event pulses also come out: one for a new low-supply condition and one for a new accepted button press. A fault register downstream records these pulses.

Top module: `supv_reset_seq`

## Requirements
- R1: The hold-off length follows the 2-bit hold code `hold_sel`: 0 gives 50 ticks, 1 gives 200 ticks, 2 gives 400 ticks and 3 gives 800 ticks.
- R2: During and after `rst`, `rst_out` is high. A low `pwr_good` makes `rst_out` high at the next clock edge. `rst_out` falls only after `pwr_good` has been high, with no other cause present, for the whole hold-off.
- R3: A high `supply_low` makes `rst_out` high at the next rising clock edge.
- R4: After `supply_low` returns low, `rst_out` falls on the clock edge that samples the N-th strobe tick, where N is the selected hold-off length.
- R5: `rst_out` stays high while the debounced button level is low. It falls 16 + N ticks after `mr_n` returns high: 16 ticks of debounce, then the hold-off.
- R6: The debounce accepts a new `mr_n` level only on the 16th consecutive tick at which the input differs from the accepted level. A press that spans 15 ticks leaves `rst_out` and `manual_evt` unchanged.
- R7: `rst_out_n` is always the complement of `rst_out`. After reset, `rst_out` is 1 and both event outputs are 0.
- R8: If a cause returns during the hold-off, the tick count clears. A full hold-off then starts again once all causes are gone.
- R9: Each rising edge of `supply_low` gives exactly one `low_supply_evt` pulse, one cycle wide, in the following cycle.
- R10: Each accepted press of the button (debounced level going low) gives exactly one `manual_evt` pulse, one cycle wide.
- R11: The hold code is captured while a cause is present or while the reset is released. Changing `hold_sel` during a running hold-off does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| tick | input | 1 | 1 kHz enable strobe, one clock wide |
| pwr_good | input | 1 | High when the power-up circuitry reports a good supply |
| supply_low | input | 1 | High while the supply comparator is below threshold (already synchronised) |
| mr_n | input | 1 | Push-button reset, active low, raw |
| hold_sel | input | 2 | Hold-off selection code |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |
| low_supply_evt | output | 1 | One-cycle pulse on a new low-supply condition |
| manual_evt | output | 1 | One-cycle pulse on a newly accepted button press |

## Verification
The bound checker watches several relations on every cycle:
- a low `pwr_good` or a high `supply_low` is followed by an asserted reset;
- the reset never falls unless power is good and the supply is above threshold;
- each event pulse lasts exactly one cycle;
- a low-supply rising edge always produces its pulse;
- a button pulse only follows a low `mr_n` and is followed by reset.

The exact tick counts depend on long windows of strobes, so only the bench scenarios can show them. These counts cover each hold-off length, the 16 + N release after a button press, the restart after a cause re-appears mid-count, the 15-tick press that must be ignored, and the frozen hold code. A behavioural model in the bench compares all outputs on every clock.

// File: rtl/supv_rst_pkg.sv
package supv_rst_pkg;

    typedef enum logic [1:0] {
        HOLD_SHORT = 2'd0,
        HOLD_MED   = 2'd1,
        HOLD_LONG  = 2'd2,
        HOLD_MAX   = 2'd3
    } hold_code_e;

    typedef struct packed {
        logic no_power;
        logic low_supply;
        logic manual;
    } cause_t;

    function automatic logic any_cause(input cause_t c);
        return c.no_power | c.low_supply | c.manual;
    endfunction

    function automatic int unsigned hold_ticks(
        input hold_code_e  code,
        input int unsigned t0,
        input int unsigned t1,
        input int unsigned t2,
        input int unsigned t3
    );
        case (code)
            HOLD_SHORT: return t0;
            HOLD_MED:   return t1;
            HOLD_LONG:  return t2;
            default:    return t3;
        endcase
    endfunction

    function automatic int unsigned max4(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c,
        input int unsigned d
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/supv_rst_debounce.sv
module supv_rst_debounce #(
    parameter int unsigned DEB_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic level,
    output logic fall_evt
);
    localparam int unsigned DW = (DEB_TICKS > 2) ? $clog2(DEB_TICKS) : 1;
    localparam logic [DW-1:0] LAST = DW'(DEB_TICKS - 1);

    logic [DW-1:0] run_q;
    logic          level_q;
    logic          evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b1;
            evt_q   <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (raw == level_q) begin
                run_q <= '0;
            end else if (tick) begin
                if (run_q == LAST) begin
                    level_q <= raw;
                    run_q   <= '0;
                    evt_q   <= ~raw;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    assign level    = level_q;
    assign fall_evt = evt_q;
endmodule

// File: rtl/supv_rst_edge.sv
module supv_rst_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise_evt
);
    logic prev_q;
    logic evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= sig;
            evt_q  <= sig & ~prev_q;
        end
    end

    assign rise_evt = evt_q;
endmodule

// File: rtl/supv_rst_holdoff.sv
module supv_rst_holdoff
    import supv_rst_pkg::*;
#(
    parameter int unsigned HOLD_T0 = 50,
    parameter int unsigned HOLD_T1 = 200,
    parameter int unsigned HOLD_T2 = 400,
    parameter int unsigned HOLD_T3 = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  cause_t     causes,
    input  hold_code_e hold_sel,
    output logic       active
);
    localparam int unsigned HOLD_MAXV = max4(HOLD_T0, HOLD_T1, HOLD_T2, HOLD_T3);
    localparam int unsigned CNT_W     = $clog2(HOLD_MAXV + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    hold_code_e       code_q;
    logic [CNT_W-1:0] last_cnt;
    logic             cause_now;

    always_comb begin
        last_cnt  = CNT_W'(hold_ticks(code_q, HOLD_T0, HOLD_T1, HOLD_T2, HOLD_T3) - 1);
        cause_now = any_cause(causes);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            code_q   <= hold_sel;
        end else if (cause_now) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            code_q   <= hold_sel;
        end else if (active_q) begin
            if (tick) begin
                if (cnt_q == last_cnt) begin
                    active_q <= 1'b0;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else begin
            code_q <= hold_sel;
        end
    end

    assign active = active_q;
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
    import supv_rst_pkg::*;
#(
    parameter int unsigned DEB_TICKS = 16,
    parameter int unsigned HOLD_T0   = 50,
    parameter int unsigned HOLD_T1   = 200,
    parameter int unsigned HOLD_T2   = 400,
    parameter int unsigned HOLD_T3   = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       pwr_good,
    input  logic       supply_low,
    input  logic       mr_n,
    input  logic [1:0] hold_sel,
    output logic       rst_out,
    output logic       rst_out_n,
    output logic       low_supply_evt,
    output logic       manual_evt
);
    logic   btn_level;
    logic   active;
    cause_t causes;

    supv_rst_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .raw      (mr_n),
        .level    (btn_level),
        .fall_evt (manual_evt)
    );

    supv_rst_edge u_low_edge (
        .clk      (clk),
        .rst      (rst),
        .sig      (supply_low),
        .rise_evt (low_supply_evt)
    );

    always_comb begin
        causes.no_power   = ~pwr_good;
        causes.low_supply = supply_low;
        causes.manual     = ~btn_level;
    end

    supv_rst_holdoff #(
        .HOLD_T0 (HOLD_T0),
        .HOLD_T1 (HOLD_T1),
        .HOLD_T2 (HOLD_T2),
        .HOLD_T3 (HOLD_T3)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .causes   (causes),
        .hold_sel (hold_code_e'(hold_sel)),
        .active   (active)
    );

    assign rst_out   = active;
    assign rst_out_n = ~active;
endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk (
    input logic clk,
    input logic rst,
    input logic pwr_good,
    input logic supply_low,
    input logic mr_n,
    input logic rst_out,
    input logic low_supply_evt,
    input logic manual_evt
);
    assert_nopower_asserts_R2: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> rst_out);

    assert_release_clean_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> $past(pwr_good && !supply_low));

    assert_low_asserts_R3: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> rst_out);

    assert_press_resets_R5: assert property (@(posedge clk) disable iff (rst)
        manual_evt |=> rst_out);

    assert_press_needs_low_R6: assert property (@(posedge clk) disable iff (rst)
        manual_evt |-> $past(!mr_n));

    assert_low_evt_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_low) |=> low_supply_evt);

    assert_low_evt_single_R9: assert property (@(posedge clk) disable iff (rst)
        low_supply_evt |=> !low_supply_evt);

    assert_man_evt_single_R10: assert property (@(posedge clk) disable iff (rst)
        manual_evt |=> !manual_evt);
endmodule

bind supv_reset_seq supv_reset_seq_chk u_chk (.*);

// File: tb/supv_reset_seq_tb.sv
`timescale 1ns/1ps
module supv_reset_seq_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       pwr_good = 1'b0;
    logic       supply_low = 1'b0;
    logic       mr_n = 1'b1;
    logic [1:0] hold_sel = 2'd0;
    logic       rst_out, rst_out_n, low_supply_evt, manual_evt;

    int errors = 0;
    int checks = 0;
    int tick_cnt = 0;
    int cyc = 0;
    bit started = 1'b0;

    supv_reset_seq u_dut (
        .clk(clk), .rst(rst), .tick(tick), .pwr_good(pwr_good),
        .supply_low(supply_low), .mr_n(mr_n), .hold_sel(hold_sel),
        .rst_out(rst_out), .rst_out_n(rst_out_n),
        .low_supply_evt(low_supply_evt), .manual_evt(manual_evt)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        tick <= ((cyc % DIV) == 0);
    end

    always @(posedge clk) if (!rst && tick) tick_cnt++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic m_level, m_rst, m_lowprev, m_evt_low, m_evt_man, m_cause;
    int   m_run, m_quiet, m_code;

    function automatic int lim(input int c);
        case (c)
            0: return 50;
            1: return 200;
            2: return 400;
            default: return 800;
        endcase
    endfunction

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            m_level = 1; m_run = 0; m_rst = 1; m_quiet = 0; m_code = hold_sel;
            m_lowprev = 0; m_evt_low = 0; m_evt_man = 0;
        end else begin
            m_cause = !pwr_good || supply_low || !m_level;
            m_evt_man = 0;
            if (mr_n == m_level) m_run = 0;
            else if (tick) begin
                if (m_run == 15) begin
                    m_level = mr_n; m_run = 0; m_evt_man = !mr_n;
                end else m_run++;
            end
            if (m_cause) begin
                m_rst = 1; m_quiet = 0; m_code = hold_sel;
            end else if (m_rst) begin
                if (tick) begin
                    m_quiet++;
                    if (m_quiet == lim(m_code)) begin m_rst = 0; m_quiet = 0; end
                end
            end else m_code = hold_sel;
            m_evt_low = supply_low && !m_lowprev;
            m_lowprev = supply_low;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            check("cycle rst_out R2/R3/R4/R5/R6/R8/R11", rst_out, m_rst);
            check("cycle rst_out_n R7", rst_out_n, !m_rst);
            check("cycle low_supply_evt R9", low_supply_evt, m_evt_low);
            check("cycle manual_evt R10", manual_evt, m_evt_man);
        end
    end

    task automatic wait_out(input logic v, input int start, output int el);
        int n;
        n = 0;
        while (rst_out !== v && n < 20000) begin
            @(negedge clk);
            n++;
        end
        el = tick_cnt - start;
    endtask

    task automatic pulse_low(input int cycles);
        @(negedge clk);
        supply_low = 1'b1;
        repeat (cycles) @(negedge clk);
        supply_low = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        int s;
        s = tick_cnt;
        while (tick_cnt - s < n) @(negedge clk);
    endtask

    initial begin
        int st, el;
        bit seen_rst, seen_evt;
        repeat (4) @(negedge clk);
        check("R7 reset rst_out", rst_out, 1);
        check("R7 reset rst_out_n", rst_out_n, 0);
        check("R7 reset evts", low_supply_evt | manual_evt, 0);
        rst = 1'b0;

        // R2 power-up with code 0
        repeat (20) @(negedge clk);
        check("R2 held while power bad", rst_out, 1);
        pwr_good = 1'b1; st = tick_cnt;
        wait_out(1'b0, st, el);
        check("R2 R1 power-up hold ticks", el, 50);

        // R3 R9 low supply
        repeat (10) @(negedge clk);
        supply_low = 1'b1;
        @(negedge clk);
        check("R3 immediate reset", rst_out, 1);
        check("R9 event pulse", low_supply_evt, 1);
        @(negedge clk);
        check("R9 pulse single", low_supply_evt, 0);
        repeat (8) @(negedge clk);
        supply_low = 1'b0; st = tick_cnt;
        wait_out(1'b0, st, el);
        check("R4 hold after low", el, 50);

        // R8 restart, code 1
        hold_sel = 2'd1;
        pulse_low(2); st = tick_cnt;
        wait_ticks(100);
        check("R8 still held mid count", rst_out, 1);
        pulse_low(2); st = tick_cnt;
        wait_out(1'b0, st, el);
        check("R8 R1 restart full 200", el, 200);

        // R1 codes 2 and 3
        for (int c = 2; c < 4; c++) begin
            hold_sel = 2'(c);
            pulse_low(3); st = tick_cnt;
            wait_out(1'b0, st, el);
            check("R1 hold length", el, lim(c));
        end

        // R11 code frozen during hold-off
        hold_sel = 2'd0;
        pulse_low(3); st = tick_cnt;
        @(negedge clk);
        hold_sel = 2'd3;
        wait_out(1'b0, st, el);
        check("R11 code frozen", el, 50);
        hold_sel = 2'd0;
        repeat (10) @(negedge clk);

        // R6 15-tick press ignored
        seen_rst = 0; seen_evt = 0;
        mr_n = 1'b0;
        for (int i = 0; i < 15 * DIV; i++) begin
            @(negedge clk);
            if (rst_out) seen_rst = 1;
            if (manual_evt) seen_evt = 1;
        end
        mr_n = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (rst_out) seen_rst = 1;
            if (manual_evt) seen_evt = 1;
        end
        check("R6 short press no reset", seen_rst, 0);
        check("R6 short press no event", seen_evt, 0);

        // R6 R5 R10 real press
        mr_n = 1'b0; st = tick_cnt;
        wait_out(1'b1, st, el);
        check("R6 accepted after 16", el, 16);
        wait_ticks(30);
        check("R5 held while pressed", rst_out, 1);
        mr_n = 1'b1; st = tick_cnt;
        wait_out(1'b0, st, el);
        check("R5 release 16 plus hold", el, 66);

        // R2 power loss during operation
        repeat (5) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        check("R2 power loss asserts", rst_out, 1);
        repeat (5) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R2 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule